// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block drives the control strobes and the data bus of an 8-bit NAND flash device for single accesses. A host issues one register access at a time. Writing the command register runs a write cycle with the command-latch strobe asserted. Writing the address register runs a write cycle with the address-latch strobe asserted. Writing the data register runs a plain write cycle. Reading the data register runs a read cycle and returns the captured byte when the cycle ends.

The length of every phase comes from one 32-bit timing register. Reads and writes each have their own setup, pulse-width and hold fields, and each field holds the clock count minus one. Each direction also has a ready-wait field. After the hold phase this field keeps the block busy for twice its value in clocks, so the device can pull its ready line low before software polls it. The ready line passes through a two-flop synchroniser before it is reported. A configuration bit holds chip enable asserted across a multi-access command, address and data sequence.

Top module: `nand_strobe_gen`

Register map (word address on `req_addr`):

| Address | Name | Access | Content |
|---|---|---|---|
| 0 | command | write | byte on bits [7:0] |
| 1 | address | write | byte on bits [7:0] |
| 2 | data | read and write | byte on bits [7:0] |
| 3 | timing | read and write | 32-bit timing fields |
| 4 | config | read and write | bit 0 forces chip enable |
| 5 | status | read | bit 0 reports device ready |

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `busy` and `rd_valid` are 0, and the timing and config registers read back as 0.
- R2: A write to address 0 runs one write cycle. `nand_cle` is high for the whole time chip enable is low, `nand_ale` stays low, `nand_we_n` pulses low once, and `nand_dq_o` carries `req_wdata[7:0]` with `nand_dq_oe` high.
- R3: A write to address 1 runs the same write cycle with `nand_ale` high and `nand_cle` low.
- R4: A write to address 2 runs a write cycle with both `nand_cle` and `nand_ale` low and the byte driven on `nand_dq_o`.
- R5: In a write cycle, chip enable is low for timing[19:16]+1 clocks before `nand_we_n` falls. `nand_we_n` then stays low for timing[27:24]+1 clocks, and chip enable stays low for timing[23:20]+1 clocks after `nand_we_n` rises. Each field covers 1 to 16 clocks.
- R6: A read of address 2 runs a read cycle. `nand_re_n` pulses low for timing[11:8]+1 clocks, after timing[3:0]+1 setup clocks and before timing[7:4]+1 hold clocks. `nand_we_n` stays high and `nand_dq_oe` stays low.
- R7: The read cycle captures `nand_dq_i` on the last clock of the `nand_re_n` low phase. In the cycle where `busy` falls, `rd_valid` is 1 and `rd_data` holds that byte with bits [31:8] zero.
- R8: After the hold phase, `busy` stays high for 2*n more clocks. n is timing[15:12] for reads and timing[31:28] for writes. With n equal to 0 there is no extra time.
- R9: A read of address 5 returns the ready line, synchronised through two flops, in bit 0. A level applied at the edge where the read is accepted is not yet visible.
- R10: While `busy` is high, a request on `req_valid` is ignored. It starts no cycle, changes no register and does not change `nand_dq_o`.
- R11: When config bit 0 is 1, `nand_ce_n` is held low, also between accesses and during the ready wait. When the bit is cleared, `nand_ce_n` returns high while idle.
- R12: A read of the timing, config or status register completes on the clock after acceptance with `rd_valid` high, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, taken when `busy` is low |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | 3 | Register word address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A NAND cycle or its ready wait is in progress |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` valid |
| rd_data | output | 32 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input |
| nand_rdy | input | 1 | Device ready line, asynchronous |

## Verification
The phase counter and phase register drive every strobe. A wrong reload value or a missed phase change therefore shows up in the same access as a setup, pulse or hold run of the wrong length on the chip-enable and strobe pins, and as a `busy` window of the wrong length. A capture taken one clock early or late shows up in `rd_data` as soon as the read completes, because the bench changes the data bus on every clock of the read pulse. A stale operation type or a request leaking through while `busy` is high shows up within one access, as the wrong latch strobe, an extra write pulse, or a changed bus byte.

// File: rtl/nand_tm_pkg.sv
package nand_tm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_WAIT  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } op_e;

  localparam int unsigned RA_CMD    = 0;
  localparam int unsigned RA_ADDR   = 1;
  localparam int unsigned RA_DATA   = 2;
  localparam int unsigned RA_TIMING = 3;
  localparam int unsigned RA_CONFIG = 4;
  localparam int unsigned RA_STATUS = 5;

endpackage

// File: rtl/nand_tm_sync.sv
module nand_tm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/nand_tm_regs.sv
module nand_tm_regs
  import nand_tm_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DQ_W    = 8,
  parameter int ADDR_W  = 3,
  localparam int REG_W  = 8 * FIELD_W,
  localparam int HALF_W = 4 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic               busy,
  input  logic               rdy_sync,
  input  logic               rd_done,
  input  logic [DQ_W-1:0]    rd_byte,
  output logic               start,
  output op_e                op,
  output logic [FIELD_W-1:0] t_setup,
  output logic [FIELD_W-1:0] t_width,
  output logic [FIELD_W-1:0] t_hold,
  output logic [FIELD_W-1:0] t_wait,
  output logic               force_ce,
  output logic               load_dq,
  output logic [DQ_W-1:0]    dq_val,
  output logic               rd_valid,
  output logic [REG_W-1:0]   rd_data
);

  logic [REG_W-1:0]  tim_q;
  logic              force_q;
  logic              accept;
  logic              is_rd;
  logic [HALF_W-1:0] half;

  assign accept = req_valid && !busy;

  always_comb begin
    start = 1'b0;
    op    = OP_CMD;
    if (accept) begin
      if (req_addr == ADDR_W'(RA_CMD) && req_write) begin
        start = 1'b1;
        op    = OP_CMD;
      end else if (req_addr == ADDR_W'(RA_ADDR) && req_write) begin
        start = 1'b1;
        op    = OP_ADDR;
      end else if (req_addr == ADDR_W'(RA_DATA)) begin
        start = 1'b1;
        op    = req_write ? OP_WDATA : OP_RDATA;
      end
    end
  end

  // Lower half of the timing word serves reads, upper half serves writes.
  assign is_rd   = (op == OP_RDATA);
  assign half    = is_rd ? tim_q[HALF_W-1:0] : tim_q[REG_W-1:HALF_W];
  assign t_setup = half[FIELD_W-1:0];
  assign t_hold  = half[2*FIELD_W-1:FIELD_W];
  assign t_width = half[3*FIELD_W-1:2*FIELD_W];
  assign t_wait  = half[4*FIELD_W-1:3*FIELD_W];

  assign load_dq  = start && !is_rd;
  assign dq_val   = req_wdata[DQ_W-1:0];
  assign force_ce = force_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tim_q    <= '0;
      force_q  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept && req_write) begin
        if (req_addr == ADDR_W'(RA_TIMING)) tim_q   <= req_wdata;
        if (req_addr == ADDR_W'(RA_CONFIG)) force_q <= req_wdata[0];
      end
      if (accept && !req_write && req_addr != ADDR_W'(RA_DATA)) begin
        rd_valid <= 1'b1;
        if (req_addr == ADDR_W'(RA_TIMING))      rd_data <= tim_q;
        else if (req_addr == ADDR_W'(RA_CONFIG)) rd_data <= REG_W'(force_q);
        else if (req_addr == ADDR_W'(RA_STATUS)) rd_data <= REG_W'(rdy_sync);
        else                                     rd_data <= '0;
      end
      if (rd_done) begin
        rd_valid <= 1'b1;
        rd_data  <= REG_W'(rd_byte);
      end
    end
  end

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ($stable(tim_q) && $stable(force_q)));

endmodule

// File: rtl/nand_tm_seq.sv
module nand_tm_seq
  import nand_tm_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  op_e                op_in,
  input  logic [FIELD_W-1:0] t_setup,
  input  logic [FIELD_W-1:0] t_width,
  input  logic [FIELD_W-1:0] t_hold,
  input  logic [FIELD_W-1:0] t_wait,
  output phase_e             phase_d,
  output op_e                op_d,
  output logic               busy,
  output logic               cap_en,
  output logic               rd_done
);

  phase_e             phase_q;
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FIELD_W-1:0] lat_width, lat_hold, lat_wait;
  logic               cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = CNT_W'(t_setup);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_PULSE;
          cnt_d   = CNT_W'(lat_width);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_PULSE: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
          cnt_d   = CNT_W'(lat_hold);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          if (lat_wait != '0) begin
            phase_d = PH_WAIT;
            cnt_d   = {lat_wait, 1'b0} - CNT_W'(1);
          end else begin
            phase_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - CNT_W'(1);
      end
    endcase
  end

  assign op_d    = (phase_q == PH_IDLE && start) ? op_in : op_q;
  assign busy    = (phase_q != PH_IDLE);
  assign cap_en  = (phase_q == PH_PULSE) && cnt_zero && (op_q == OP_RDATA);
  assign rd_done = busy && (phase_d == PH_IDLE) && (op_q == OP_RDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      op_q      <= OP_CMD;
      cnt_q     <= '0;
      lat_width <= '0;
      lat_hold  <= '0;
      lat_wait  <= '0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      if (phase_q == PH_IDLE && start) begin
        lat_width <= t_width;
        lat_hold  <= t_hold;
        lat_wait  <= t_wait;
      end
    end
  end

  // R5
  pulse_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PULSE && cnt_zero) |=> (phase_q == PH_HOLD));

  // R8
  wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT && cnt_zero) |=> (phase_q == PH_IDLE));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/nand_tm_pins.sv
module nand_tm_pins
  import nand_tm_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_e          phase_d,
  input  op_e             op_d,
  input  logic            force_ce,
  input  logic            load_dq,
  input  logic [DQ_W-1:0] dq_val,
  input  logic            cap_en,
  input  logic [DQ_W-1:0] dq_i,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_o,
  output logic [DQ_W-1:0] rd_byte
);

  logic active, pulse, is_rd;

  always_comb begin
    active = (phase_d == PH_SETUP) || (phase_d == PH_PULSE) || (phase_d == PH_HOLD);
    pulse  = (phase_d == PH_PULSE);
    is_rd  = (op_d == OP_RDATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n    <= 1'b1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dq_o    <= '0;
      rd_byte <= '0;
    end else begin
      ce_n  <= !(active || force_ce);
      cle   <= active && (op_d == OP_CMD);
      ale   <= active && (op_d == OP_ADDR);
      we_n  <= !(pulse && !is_rd);
      re_n  <= !(pulse && is_rd);
      dq_oe <= active && !is_rd;
      if (load_dq) dq_o    <= dq_val;
      if (cap_en)  rd_byte <= dq_i;
    end
  end

  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  // R5
  strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> !ce_n);

  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_tm_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int DQ_W        = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = 8 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DQ_W-1:0]   nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DQ_W-1:0]   nand_dq_i,
  input  logic              nand_rdy
);

  logic               start, force_ce, load_dq, cap_en, rd_done, rdy_sync;
  op_e                op, op_d;
  phase_e             phase_d;
  logic [FIELD_W-1:0] t_setup, t_width, t_hold, t_wait;
  logic [DQ_W-1:0]    dq_val, rd_byte;

  nand_tm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (nand_rdy),
    .q   (rdy_sync)
  );

  nand_tm_regs #(.FIELD_W(FIELD_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .rdy_sync  (rdy_sync),
    .rd_done   (rd_done),
    .rd_byte   (rd_byte),
    .start     (start),
    .op        (op),
    .t_setup   (t_setup),
    .t_width   (t_width),
    .t_hold    (t_hold),
    .t_wait    (t_wait),
    .force_ce  (force_ce),
    .load_dq   (load_dq),
    .dq_val    (dq_val),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  nand_tm_seq #(.FIELD_W(FIELD_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_in   (op),
    .t_setup (t_setup),
    .t_width (t_width),
    .t_hold  (t_hold),
    .t_wait  (t_wait),
    .phase_d (phase_d),
    .op_d    (op_d),
    .busy    (busy),
    .cap_en  (cap_en),
    .rd_done (rd_done)
  );

  nand_tm_pins #(.DQ_W(DQ_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .phase_d  (phase_d),
    .op_d     (op_d),
    .force_ce (force_ce),
    .load_dq  (load_dq),
    .dq_val   (dq_val),
    .cap_en   (cap_en),
    .dq_i     (nand_dq_i),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_oe    (nand_dq_oe),
    .dq_o     (nand_dq_o),
    .rd_byte  (rd_byte)
  );

  // R8
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));

endmodule

// File: tb/tb_nand_strobe_gen.sv
module tb_nand_strobe_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rd_valid;
  logic [31:0] rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rdy = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nand_strobe_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tim(input int rs, rh, rw, rn, ws, wh, ww, wn);
    return {wn[3:0], ww[3:0], wh[3:0], ws[3:0], rn[3:0], rw[3:0], rh[3:0], rs[3:0]};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  // Runs one NAND access and measures every phase at the pins.
  task automatic run_cycle(input logic [2:0] a, input bit wr, input logic [7:0] b,
                           input int s, w, h, n, input bit forced, input string lbl);
    int busy_n = 0, ce_low = 0, str_low = 0, pre = 0, post = 0;
    int cle_n = 0, ale_n = 0, oe_n = 0, other_low = 0;
    bit seen = 1'b0;
    logic [7:0] dqv = '0;
    logic st;
    int act = s + w + h + 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = {24'h0, b};
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    while (busy && busy_n < 2000) begin
      busy_n++;
      st = wr ? nand_we_n : nand_re_n;
      if (!(wr ? nand_re_n : nand_we_n)) other_low++;
      if (!nand_ce_n) ce_low++;
      if (!st) begin
        str_low++; seen = 1'b1;
        if (!wr) nand_dq_i = 8'h30 + 8'(str_low);
      end else if (!nand_ce_n) begin
        if (!seen) pre++; else post++;
      end
      if (nand_cle) cle_n++;
      if (nand_ale) ale_n++;
      if (nand_dq_oe) begin oe_n++; dqv = nand_dq_o; end
      @(negedge clk);
    end
    chk({"R8 busy length ", lbl}, busy_n, act + 2 * n);
    chk({wr ? "R5" : "R6", " strobe width ", lbl}, str_low, w + 1);
    chk({wr ? "R5" : "R6", " other strobe idle ", lbl}, other_low, 0);
    if (!forced) begin
      chk({wr ? "R5" : "R6", " setup ", lbl}, pre, s + 1);
      chk({wr ? "R5" : "R6", " hold ", lbl}, post, h + 1);
      chk({"R5 ce low ", lbl}, ce_low, act);
    end else begin
      chk({"R11 ce held ", lbl}, ce_low, busy_n);
    end
    chk({"R2 cle ", lbl}, cle_n, (wr && a == 3'd0) ? act : 0);
    chk({"R3 ale ", lbl}, ale_n, (wr && a == 3'd1) ? act : 0);
    if (wr) begin
      chk({"R4 bus driven ", lbl}, oe_n, act);
      chk({"R4 bus byte ", lbl}, dqv, b);
    end else begin
      chk({"R6 bus released ", lbl}, oe_n, 0);
      chk({"R7 rd_valid ", lbl}, rd_valid, 1);
      chk({"R7 rd_data ", lbl}, rd_data, 32'h30 + w + 1);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n", nand_we_n, 1);
    chk("R1 re_n", nand_re_n, 1);
    chk("R1 cle/ale", {nand_cle, nand_ale}, 0);
    chk("R1 dq_oe", nand_dq_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    reg_read(3'd3, d, v);
    chk("R1 timing zero", d, 0);
    chk("R12 timing read valid", v, 1);
    reg_read(3'd4, d, v);
    chk("R1 config zero", d, 0);
  endtask

  task automatic t_writes();
    logic [31:0] d; logic v;
    reg_write(3'd3, tim(0, 0, 0, 0, 2, 1, 3, 0));
    reg_read(3'd3, d, v);
    chk("R12 timing readback", d, tim(0, 0, 0, 0, 2, 1, 3, 0));
    chk("R12 busy low on reg read", busy, 0);
    run_cycle(3'd0, 1'b1, 8'h70, 2, 3, 1, 0, 1'b0, "cmd");
    reg_write(3'd3, tim(0, 0, 0, 0, 2, 1, 3, 2));
    run_cycle(3'd1, 1'b1, 8'h5C, 2, 3, 1, 2, 1'b0, "addr");
    reg_write(3'd3, tim(7, 7, 7, 7, 0, 0, 15, 0));
    run_cycle(3'd2, 1'b1, 8'hA5, 0, 15, 0, 0, 1'b0, "data long pulse");
    reg_write(3'd3, tim(0, 0, 0, 0, 15, 15, 0, 15));
    run_cycle(3'd2, 1'b1, 8'h3B, 15, 0, 15, 15, 1'b0, "data max setup/hold");
  endtask

  task automatic t_reads();
    reg_write(3'd3, tim(1, 2, 3, 1, 9, 9, 9, 9));
    run_cycle(3'd2, 1'b0, 8'h00, 1, 3, 2, 1, 1'b0, "read");
    reg_write(3'd3, tim(0, 0, 0, 0, 5, 5, 5, 5));
    run_cycle(3'd2, 1'b0, 8'h00, 0, 0, 0, 0, 1'b0, "read minimal");
    reg_write(3'd3, tim(0, 0, 15, 0, 0, 0, 0, 0));
    run_cycle(3'd2, 1'b0, 8'h00, 0, 15, 0, 0, 1'b0, "read long pulse");
  endtask

  task automatic t_status();
    logic [31:0] d; logic v;
    nand_rdy = 1'b0;
    repeat (3) @(negedge clk);
    reg_read(3'd5, d, v);
    chk("R9 not ready", d, 0);
    chk("R12 status read valid", v, 1);
    @(negedge clk);
    nand_rdy = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 sync latency", rd_data, 0);
    repeat (2) @(negedge clk);
    reg_read(3'd5, d, v);
    chk("R9 ready seen", d, 1);
  endtask

  task automatic t_stall();
    logic [31:0] d; logic v;
    int we_low = 0;
    logic [31:0] t1 = tim(0, 0, 0, 0, 1, 1, 1, 0);
    reg_write(3'd3, t1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 32'h90;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!nand_we_n) we_low++;
      if (i == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 32'hEE;
      end else if (i == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd3; req_wdata = 32'hFFFF_FFFF;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R10 single write pulse", we_low, 2);
    chk("R10 bus byte kept", nand_dq_o, 8'h90);
    chk("R10 busy idle", busy, 0);
    reg_read(3'd3, d, v);
    chk("R10 timing unchanged", d, t1);
  endtask

  task automatic t_force();
    logic [31:0] d; logic v;
    reg_write(3'd4, 32'h1);
    @(negedge clk);
    chk("R11 ce low idle", nand_ce_n, 0);
    reg_read(3'd4, d, v);
    chk("R12 config readback", d, 1);
    reg_write(3'd3, tim(0, 0, 0, 0, 1, 0, 1, 1));
    run_cycle(3'd0, 1'b1, 8'hFF, 1, 1, 0, 1, 1'b1, "forced cmd");
    chk("R11 ce low after", nand_ce_n, 0);
    reg_write(3'd4, 32'h0);
    @(negedge clk);
    chk("R11 ce released", nand_ce_n, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_writes();
    t_reads();
    t_status();
    t_stall();
    t_force();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule